// File: doc/BRIEF.md
# Flash erase command sequencer

This block is the command front end of a behavioural flash array made of 32 erase blocks. A host writes one-byte command codes into it over a valid/ready command channel. A block erase or a full-chip erase starts only when a setup code is followed directly by a confirm code. At confirm time the block checks three things: the programming-supply qualify input, the write-protect pin and the per-block lock bits. A command that passes these checks runs an internal erase for a parameterised number of cycles. An erased word reads back as all ones.

Reads are combinational. In read-array mode a read returns the addressed array word. A read returns the status byte in any of these cases:
- a setup code has been written;
- an erase is running;
- an erase command sequence has been taken and no later command has changed the mode.

Status bit 7 is the ready flag. The `op_ready` pin carries the same value as a level. Each kind of failure sets its own pair of error bits. These bits stay set until the host writes the clear code.

The command channel has one back-pressure rule. `cmd_ready` is low for the whole time an erase runs. A command held on `cmd_valid` in that time waits, and it is taken on the first cycle that `cmd_ready` is high. A transfer takes place on any clock edge where both `cmd_valid` and `cmd_ready` are high. The lock bits are loaded through a separate configuration port.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset the block is in read-array mode, `op_ready` and `cmd_ready` are high, all error bits and lock bits are clear, and word w of block b reads 0xA000 | (b << 4) | w.
- R2: The codes are: 0x20 block-erase setup, with the block taken from `cmd_blk` at setup; 0xA7 chip-erase setup; 0xD0 confirm. Any other code written after a setup code sets status bits 4 and 5, erases nothing and leaves the block in status mode.
- R3: If `vpp_ok` is low when the confirm code is taken, status bits 3 and 5 are set, no erase starts and the array is unchanged. This holds for both kinds of erase.
- R4: A block erase of a locked block while `wp_n` is low sets status bits 1 and 5 and erases nothing. When `wp_n` is high, the lock bit is overridden and the erase runs.
- R5: An accepted block erase keeps `op_ready` low for exactly ERASE_CYCLES cycles after the confirm edge. After that the target block reads 0xFFFF and every other block is unchanged.
- R6: A full-chip erase visits blocks 0 to 31 in order. It spends one cycle on each block and ERASE_CYCLES more cycles on each unprotected block, so it is busy for 32 + ERASE_CYCLES × (unprotected blocks) cycles. A block is protected when its lock bit is set and `wp_n` was low at confirm. Protected blocks keep their contents.
- R7: Once a setup code is taken, reads return {8'h00, status}. Status mode lasts until code 0xFF returns the block to read-array mode.
- R8: Status bit 7 and `op_ready` are 1 when the block is ready and 0 while an erase runs. `cmd_ready` is low while the block is busy.
- R9: Each cycle that `suspend_req` is high during a block erase adds one cycle to the erase time. During a full-chip erase, `suspend_req` has no effect.
- R10: Error bits are sticky. They survive later commands and later erases. Code 0x50 clears bits 1, 3, 4 and 5 and leaves the read mode unchanged.
- R11: In read-array mode or status mode, a code other than 0x20, 0xA7, 0x50 or 0xFF has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command byte is offered |
| cmd_ready | output | 1 | A command can be taken (low while erasing) |
| cmd_blk | input | BLK_W | Block address that comes with the command |
| cmd_data | input | 8 | Command code |
| rd_addr | input | BLK_W+WRD_W | Read address, given as {block, word} |
| rd_data | output | DATA_W | Array word, or {8'h00, status} |
| vpp_ok | input | 1 | Programming supply is above the lockout level |
| wp_n | input | 1 | Write-protect pin; when high, lock bits are overridden |
| suspend_req | input | 1 | Request to pause a block erase |
| lock_we | input | 1 | Load a lock bit |
| lock_blk | input | BLK_W | Block whose lock bit is loaded |
| lock_set | input | 1 | Lock value to load |
| op_ready | output | 1 | Ready/busy level |

## Verification
A command changes the mode and the status on the clock edge that takes it. So reads, `op_ready` and `cmd_ready` show the new state at the falling edge that follows. A block erase holds `op_ready` low for ERASE_CYCLES falling edges, plus one for each suspended cycle. A chip erase holds it low for 32 + ERASE_CYCLES × (unprotected blocks) falling edges. The erased contents can be read once `op_ready` rises and a 0xFF has been written. The bench's behavioural model advances on each rising edge and is compared with all outputs shortly after each falling edge. Directed reads and busy-length counts are taken at those same settled points.

// File: rtl/fes_pkg.sv
package fes_pkg;
  typedef enum logic [1:0] {M_ARRAY, M_STATUS, M_BE_SETUP, M_CE_SETUP} mode_t;
  typedef enum logic [1:0] {E_IDLE, E_SCAN, E_ERASE} eng_t;

  localparam logic [7:0] CMD_BLK_SETUP  = 8'h20;
  localparam logic [7:0] CMD_CHIP_SETUP = 8'hA7;
  localparam logic [7:0] CMD_CONFIRM    = 8'hD0;
  localparam logic [7:0] CMD_CLEAR      = 8'h50;
  localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;

  localparam int SB_ERASE = 5;
  localparam int SB_SEQ   = 4;
  localparam int SB_VPP   = 3;
  localparam int SB_LOCK  = 1;
endpackage

// File: rtl/fes_array.sv
module fes_array #(
  parameter int NBLK   = 32,
  parameter int WORDS  = 4,
  parameter int DATA_W = 16,
  localparam int BLK_W = $clog2(NBLK),
  localparam int WRD_W = $clog2(WORDS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wipe_en,
  input  logic [BLK_W-1:0]       wipe_blk,
  input  logic                   lock_we,
  input  logic [BLK_W-1:0]       lock_blk,
  input  logic                   lock_set,
  input  logic [BLK_W+WRD_W-1:0] rd_addr,
  output logic [DATA_W-1:0]      rd_word,
  output logic [NBLK-1:0]        lock_bits
);
  logic [NBLK-1:0][DATA_W-1:0] blk_word;
  logic [WRD_W-1:0] rd_wi;
  logic [BLK_W-1:0] rd_bi;

  assign rd_wi = rd_addr[WRD_W-1:0];
  assign rd_bi = rd_addr[BLK_W+WRD_W-1:WRD_W];

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    logic [WORDS-1:0][DATA_W-1:0] row;
    for (genvar w = 0; w < WORDS; w++) begin : g_wd
      localparam logic [31:0] SEED = 32'hA000 | (32'(b) << 4) | 32'(w);
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= DATA_W'(SEED);
        else if (wipe_en && wipe_blk == BLK_W'(b)) q <= '1;
      end
      assign row[w] = q;
    end
    assign blk_word[b] = row[rd_wi];
  end

  assign rd_word = blk_word[rd_bi];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_bits <= '0;
    else if (lock_we) lock_bits[lock_blk] <= lock_set;
  end
endmodule

// File: rtl/fes_erase_engine.sv
module fes_erase_engine
  import fes_pkg::*;
#(
  parameter int NBLK         = 32,
  parameter int ERASE_CYCLES = 6,
  localparam int BLK_W = $clog2(NBLK),
  localparam int CNT_W = $clog2(ERASE_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_blk,
  input  logic             start_chip,
  input  logic [BLK_W-1:0] start_idx,
  input  logic [NBLK-1:0]  prot_mask,
  input  logic             suspend_req,
  output logic             busy,
  output logic             wipe_en,
  output logic [BLK_W-1:0] wipe_blk,
  output logic             chip_mode,
  output logic [NBLK-1:0]  prot_q
);
  localparam logic [BLK_W-1:0] LAST = BLK_W'(NBLK - 1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(ERASE_CYCLES - 1);

  eng_t st;
  logic [BLK_W-1:0] cur;
  logic [CNT_W-1:0] cnt;
  logic hold;

  assign hold     = suspend_req && !chip_mode;
  assign busy     = (st != E_IDLE);
  assign wipe_en  = (st == E_ERASE) && !hold && (cnt == '0);
  assign wipe_blk = cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= E_IDLE;
      cur       <= '0;
      cnt       <= '0;
      chip_mode <= 1'b0;
      prot_q    <= '0;
    end else begin
      unique case (st)
        E_IDLE: begin
          if (start_blk) begin
            st        <= E_ERASE;
            cur       <= start_idx;
            cnt       <= CNT_INIT;
            chip_mode <= 1'b0;
            prot_q    <= '0;
          end else if (start_chip) begin
            st        <= E_SCAN;
            cur       <= '0;
            chip_mode <= 1'b1;
            prot_q    <= prot_mask;
          end
        end
        E_SCAN: begin
          if (prot_q[cur]) begin
            if (cur == LAST) st <= E_IDLE;
            else cur <= cur + 1'b1;
          end else begin
            st  <= E_ERASE;
            cnt <= CNT_INIT;
          end
        end
        E_ERASE: begin
          if (!hold) begin
            if (cnt == '0) begin
              if (!chip_mode || cur == LAST) st <= E_IDLE;
              else begin
                cur <= cur + 1'b1;
                st  <= E_SCAN;
              end
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        end
        default: st <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fes_cmd_fsm.sv
module fes_cmd_fsm
  import fes_pkg::*;
#(
  parameter int NBLK = 32,
  localparam int BLK_W = $clog2(NBLK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_fire,
  input  logic [7:0]       cmd_data,
  input  logic [BLK_W-1:0] cmd_blk,
  input  logic             vpp_ok,
  input  logic             wp_n,
  input  logic [NBLK-1:0]  lock_bits,
  output mode_t            mode,
  output logic             start_blk,
  output logic             start_chip,
  output logic [BLK_W-1:0] target_blk,
  output logic [NBLK-1:0]  prot_mask,
  output logic [7:0]       err_bits,
  output logic             clr_hit
);
  logic confirm;
  logic blk_locked;

  assign confirm    = cmd_fire && (cmd_data == CMD_CONFIRM);
  assign blk_locked = lock_bits[target_blk] && !wp_n;
  assign prot_mask  = lock_bits & {NBLK{~wp_n}};
  assign start_blk  = confirm && (mode == M_BE_SETUP) && vpp_ok && !blk_locked;
  assign start_chip = confirm && (mode == M_CE_SETUP) && vpp_ok;
  assign clr_hit    = cmd_fire && (mode == M_ARRAY || mode == M_STATUS)
                      && (cmd_data == CMD_CLEAR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode       <= M_ARRAY;
      err_bits   <= '0;
      target_blk <= '0;
    end else if (cmd_fire) begin
      unique case (mode)
        M_BE_SETUP, M_CE_SETUP: begin
          mode <= M_STATUS;
          if (cmd_data != CMD_CONFIRM) begin
            err_bits[SB_SEQ]   <= 1'b1;
            err_bits[SB_ERASE] <= 1'b1;
          end else if (!vpp_ok) begin
            err_bits[SB_VPP]   <= 1'b1;
            err_bits[SB_ERASE] <= 1'b1;
          end else if (mode == M_BE_SETUP && blk_locked) begin
            err_bits[SB_LOCK]  <= 1'b1;
            err_bits[SB_ERASE] <= 1'b1;
          end
        end
        default: begin
          unique case (cmd_data)
            CMD_BLK_SETUP: begin
              mode       <= M_BE_SETUP;
              target_blk <= cmd_blk;
            end
            CMD_CHIP_SETUP: mode <= M_CE_SETUP;
            CMD_CLEAR:      err_bits <= '0;
            CMD_READ_ARRAY: mode <= M_ARRAY;
            default: ;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import fes_pkg::*;
#(
  parameter int NBLK         = 32,
  parameter int WORDS        = 4,
  parameter int DATA_W       = 16,
  parameter int ERASE_CYCLES = 6,
  localparam int BLK_W = $clog2(NBLK),
  localparam int WRD_W = $clog2(WORDS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  output logic                   cmd_ready,
  input  logic [BLK_W-1:0]       cmd_blk,
  input  logic [7:0]             cmd_data,
  input  logic [BLK_W+WRD_W-1:0] rd_addr,
  output logic [DATA_W-1:0]      rd_data,
  input  logic                   vpp_ok,
  input  logic                   wp_n,
  input  logic                   suspend_req,
  input  logic                   lock_we,
  input  logic [BLK_W-1:0]       lock_blk,
  input  logic                   lock_set,
  output logic                   op_ready
);
  mode_t            mode;
  logic             busy, cmd_fire, start_blk, start_chip, clr_hit;
  logic             wipe_en, eng_chip;
  logic [BLK_W-1:0] target_blk, wipe_blk;
  logic [NBLK-1:0]  prot_mask, eng_prot, lock_bits;
  logic [7:0]       err_bits, status;
  logic [DATA_W-1:0] rd_word;

  assign cmd_ready = !busy;
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign op_ready  = !busy;
  assign status    = {!busy, err_bits[6:0]};
  assign rd_data   = (mode == M_ARRAY) ? rd_word : DATA_W'(status);

  fes_cmd_fsm #(.NBLK(NBLK)) u_fsm (
    .clk, .rst_n, .cmd_fire, .cmd_data, .cmd_blk, .vpp_ok, .wp_n,
    .lock_bits, .mode, .start_blk, .start_chip, .target_blk,
    .prot_mask, .err_bits, .clr_hit
  );

  fes_erase_engine #(.NBLK(NBLK), .ERASE_CYCLES(ERASE_CYCLES)) u_eng (
    .clk, .rst_n, .start_blk, .start_chip, .start_idx(target_blk),
    .prot_mask, .suspend_req, .busy, .wipe_en, .wipe_blk,
    .chip_mode(eng_chip), .prot_q(eng_prot)
  );

  fes_array #(.NBLK(NBLK), .WORDS(WORDS), .DATA_W(DATA_W)) u_arr (
    .clk, .rst_n, .wipe_en, .wipe_blk, .lock_we, .lock_blk, .lock_set,
    .rd_addr, .rd_word, .lock_bits
  );
endmodule

// File: rtl/fes_checker.sv
module fes_checker #(
  parameter int NBLK   = 32,
  parameter int DATA_W = 16,
  localparam int BLK_W = $clog2(NBLK)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_ready,
  input logic              vpp_ok,
  input logic [DATA_W-1:0] rd_data,
  input logic [7:0]        err_bits,
  input logic              clr_hit,
  input logic              wipe_en,
  input logic [BLK_W-1:0]  wipe_blk,
  input logic [NBLK-1:0]   eng_prot,
  input logic              eng_chip
);
  // R3: an erase only begins if the supply qualified on the starting edge
  p_start_needs_vpp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_ready && $past(op_ready)) |-> $past(vpp_ok));

  // R4: a protected block is never wiped
  p_wipe_unprot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_en |-> !eng_prot[wipe_blk]);

  // R5: the final wipe of an operation is followed by ready
  p_done_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wipe_en && (!eng_chip || wipe_blk == BLK_W'(NBLK - 1))) |=> op_ready);

  // R7: while busy a read shows a status byte with the ready bit low
  p_busy_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !op_ready |-> (rd_data[DATA_W-1:8] == '0 && !rd_data[7]));

  // R10: the erase-fail bit stays set until a clear command
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_bits[5] && !clr_hit) |=> err_bits[5]);
endmodule

bind flash_erase_seq fes_checker #(.NBLK(NBLK), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_ready(op_ready), .vpp_ok(vpp_ok),
  .rd_data(rd_data), .err_bits(err_bits), .clr_hit(clr_hit),
  .wipe_en(wipe_en), .wipe_blk(wipe_blk), .eng_prot(eng_prot),
  .eng_chip(eng_chip)
);

// File: tb/flash_erase_seq_test.sv
module flash_erase_seq_test;
  localparam int NB = 32, WPB = 4, EC = 6, BW = 5, WW = 2, AW = 7;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cmd_valid, vpp_ok, wp_n, suspend_req, lock_we, lock_set;
  logic [BW-1:0] cmd_blk, lock_blk;
  logic [7:0] cmd_data;
  logic [AW-1:0] rd_addr;
  wire cmd_ready, op_ready;
  wire [15:0] rd_data;

  flash_erase_seq #(.NBLK(NB), .WORDS(WPB), .DATA_W(16), .ERASE_CYCLES(EC)) uut (
    .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_blk, .cmd_data, .rd_addr,
    .rd_data, .vpp_ok, .wp_n, .suspend_req, .lock_we, .lock_blk, .lock_set,
    .op_ready
  );

  int total = 0, bad = 0, cyc = 0;

  // behavioural reference model
  logic [15:0] m_mem [NB][WPB];
  bit m_lock [NB];
  bit m_prot [NB];
  int m_mode;   // 0 array, 1 status, 2 block setup, 3 chip setup
  logic [7:0] m_err;
  int m_left, m_blk;
  bit m_single;

  function automatic logic [15:0] seed(int b, int w);
    return 16'(32'hA000 | (b << 4) | w);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) begin
        m_lock[b] = 0;
        for (int w = 0; w < WPB; w++) m_mem[b][w] = seed(b, w);
      end
      m_mode = 0; m_err = 0; m_left = 0; m_blk = 0; m_single = 0;
    end else begin
      if (m_left > 0) begin
        if (!(m_single && suspend_req)) m_left--;
        if (m_left == 0) begin
          for (int b = 0; b < NB; b++)
            if (m_single ? (b == m_blk) : !m_prot[b])
              for (int w = 0; w < WPB; w++) m_mem[b][w] = 16'hFFFF;
        end
      end else if (cmd_valid) begin
        if (m_mode == 2 || m_mode == 3) begin
          if (cmd_data != 8'hD0) m_err |= 8'h30;
          else if (!vpp_ok) m_err |= 8'h28;
          else if (m_mode == 2 && m_lock[m_blk] && !wp_n) m_err |= 8'h22;
          else if (m_mode == 2) begin m_left = EC; m_single = 1; end
          else begin
            int n = 0;
            for (int b = 0; b < NB; b++) begin
              m_prot[b] = m_lock[b] && !wp_n;
              if (!m_prot[b]) n++;
            end
            m_left = NB + EC * n; m_single = 0;
          end
          m_mode = 1;
        end else begin
          case (cmd_data)
            8'h20: begin m_mode = 2; m_blk = int'(cmd_blk); end
            8'hA7: m_mode = 3;
            8'h50: m_err = 0;
            8'hFF: m_mode = 0;
            default: ;
          endcase
        end
      end
      if (lock_we) m_lock[lock_blk] = lock_set;
    end
  end

  function automatic logic [15:0] m_read();
    if (m_mode == 0) return m_mem[rd_addr[AW-1:WW]][rd_addr[WW-1:0]];
    return {8'h00, (m_left == 0), m_err[6:0]};
  endfunction

  // R7 R8: cycle compare against the model, settled after each falling edge
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      total++;
      if (op_ready !== (m_left == 0) || cmd_ready !== (m_left == 0) ||
          rd_data !== m_read()) begin
        bad++;
        $display("FAIL R8 cycle compare actual=%b/%b/%h expected=%b/%b/%h",
                 op_ready, cmd_ready, rd_data, (m_left == 0), (m_left == 0), m_read());
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL R8 watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input int b, input logic [7:0] d);
    @(negedge clk);
    while (!op_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_blk = BW'(b); cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic rd(input int b, input int w, output logic [15:0] v);
    @(negedge clk);
    rd_addr = AW'(b * WPB + w);
    #1 v = rd_data;
  endtask

  task automatic set_lock(input int b, input bit v);
    @(negedge clk);
    lock_we = 1'b1; lock_blk = BW'(b); lock_set = v;
    @(negedge clk);
    lock_we = 1'b0;
  endtask

  // counts busy falling edges; susp_from/susp_to select cycles with suspend high
  task automatic busy_len(input int susp_from, input int susp_to, output int n);
    n = 0;
    while (!op_ready && n < 1000) begin
      suspend_req = (n >= susp_from && n < susp_to);
      n++;
      @(negedge clk);
    end
    suspend_req = 1'b0;
  endtask

  initial begin
    logic [15:0] v;
    int n;
    rst_n = 0; cmd_valid = 0; cmd_blk = 0; cmd_data = 0; rd_addr = 0;
    vpp_ok = 1; wp_n = 1; suspend_req = 0; lock_we = 0; lock_blk = 0; lock_set = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    rd(2, 1, v); check("R1 reset array word", v, 16'hA021);
    check("R1 reset ready", {15'd0, op_ready}, 16'd1);

    send(0, 8'h33);
    rd(2, 1, v); check("R11 unknown code ignored", v, 16'hA021);

    send(3, 8'h20); send(3, 8'hD0);
    busy_len(0, 0, n); check("R5 block erase busy length", 16'(n), 16'(EC));
    rd(3, 0, v); check("R7 status after erase", v, 16'h0080);
    send(0, 8'hFF);
    rd(3, 2, v); check("R5 target erased", v, 16'hFFFF);
    rd(4, 2, v); check("R5 neighbour intact", v, 16'hA042);

    send(5, 8'h20); send(5, 8'h40);
    rd(5, 0, v); check("R2 bad sequence status", v, 16'h00B0);
    send(0, 8'hFF);
    rd(5, 0, v); check("R2 bad sequence no erase", v, 16'hA050);

    send(5, 8'h20); send(5, 8'hD0);
    busy_len(0, 0, n);
    rd(0, 0, v); check("R10 error bits sticky", v, 16'h00B0);
    send(0, 8'h50);
    rd(0, 0, v); check("R10 clear keeps status mode", v, 16'h0080);
    send(0, 8'hFF);
    rd(5, 1, v); check("R5 erase after error", v, 16'hFFFF);

    send(0, 8'hA7); send(0, 8'h20);
    rd(0, 0, v); check("R2 chip bad sequence", v, 16'h00B0);
    send(0, 8'h50);

    vpp_ok = 0;
    send(6, 8'h20); send(6, 8'hD0);
    rd(0, 0, v); check("R3 supply low block", v, 16'h00A8);
    send(0, 8'h50);
    send(0, 8'hA7); send(0, 8'hD0);
    rd(0, 0, v); check("R3 supply low chip", v, 16'h00A8);
    vpp_ok = 1;
    send(0, 8'h50); send(0, 8'hFF);
    rd(6, 3, v); check("R3 array unchanged", v, 16'hA063);
    rd(8, 0, v); check("R3 chip array unchanged", v, 16'hA080);

    set_lock(7, 1); wp_n = 0;
    send(7, 8'h20); send(7, 8'hD0);
    rd(0, 0, v); check("R4 locked block status", v, 16'h00A2);
    send(0, 8'h50); send(0, 8'hFF);
    rd(7, 0, v); check("R4 locked block intact", v, 16'hA070);
    wp_n = 1;
    send(7, 8'h20); send(7, 8'hD0);
    busy_len(0, 0, n); check("R4 override busy length", 16'(n), 16'(EC));
    send(0, 8'hFF);
    rd(7, 0, v); check("R4 override erased", v, 16'hFFFF);

    send(9, 8'h20); send(9, 8'hD0);
    busy_len(1, 6, n); check("R9 suspend stretches block erase", 16'(n), 16'(EC + 5));

    set_lock(7, 0); set_lock(0, 1); set_lock(10, 1); set_lock(31, 1);
    wp_n = 0;
    send(0, 8'hA7); send(0, 8'hD0);
    busy_len(0, 10000, n);
    check("R6 R9 chip busy length", 16'(n), 16'(NB + EC * (NB - 3)));
    rd(0, 0, v); check("R7 status after chip erase", v, 16'h0080);
    send(0, 8'hFF);
    rd(0, 0, v);  check("R6 locked block 0 kept", v, 16'hA000);
    rd(10, 1, v); check("R6 locked block 10 kept", v, 16'hA0A1);
    rd(31, 3, v); check("R6 locked block 31 kept", v, 16'hA1F3);
    rd(1, 2, v);  check("R6 block 1 erased", v, 16'hFFFF);
    rd(11, 0, v); check("R6 block 11 erased", v, 16'hFFFF);
    rd(30, 3, v); check("R6 block 30 erased", v, 16'hFFFF);

    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule